// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides, every clock cycle, which of sixteen time-multiplexed DMA channels is served next. Requests reach it from two sources. Eight internal FIFOs each raise a pair of level signals: a watermark line (the FIFO holds data to be drained) and a hungry line (the FIFO has room for more data). Four external peripheral request lines also feed in. Each channel can be enabled or masked, and each carries a 4-bit priority level.

A mode input selects how the winner is chosen. In priority mode the highest level wins, and a rotating pointer settles ties. In round-robin mode the channel after the last one served wins, whatever the levels are. A grant lasts one service slot, and the next cycle is arbitrated again from scratch.

External requests are edge-captured into pending flags. Two of the external lines complete with an explicit done pulse. The other two complete as soon as they are granted.

Top module: `dma_chan_arb`

## Requirements
- R1: Channel 2f requests while FIFO f's watermark line is high, and channel 2f+1 requests while FIFO f's hungry line is high (f = 0..7). Both are level-sensitive.
- R2: External line k (k = 0..3) feeds channel 12+k through a pending flag. The flag is set at the first clock edge that sees the line high after it was low. It is ORed with that channel's internal request, so the first grant comes one cycle after the flag is set.
- R3: For external lines 2 and 3 the pending flag clears at the edge where the channel is granted. A new rising edge in that same cycle keeps the flag set.
- R4: For external lines 0 and 1 the pending flag survives any number of grants. It clears only at an edge where that line's done input is 1. A rising edge of the request in the same cycle keeps it set.
- R5: A channel whose enable bit is 0 is never granted, whatever its priority or pending state.
- R6: The grant is registered. The requests present before an edge decide grant_vld and grant_idx after that edge, for one cycle only. With no enabled request, grant_vld is 0 after the edge.
- R7: With mode_rr = 0, the winner has the largest 4-bit level among requesting channels. Channel i's level is chan_prio[4i+3:4i], and 15 is the most urgent.
- R8: With mode_rr = 0, a tie at the top level goes to the first tied channel found searching upward, with wrap, from the channel after the last granted one.
- R9: With mode_rr = 1, levels are ignored. The winner is the first requesting channel searching upward, with wrap, from the channel after the last granted one. Every grant in either mode moves this pointer.
- R10: grant_ack is one-hot at bit grant_idx while grant_vld is 1, and all zero otherwise.
- R11: After reset grant_vld = 0, grant_idx = 0, grant_ack = 0, and the first search starts at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rr | input | 1 | 0 = priority arbitration, 1 = round-robin |
| chan_en | input | 16 | Per-channel enable |
| chan_prio | input | 64 | 4-bit level per channel, channel i at [4i+3:4i] |
| fifo_wm | input | 8 | Watermark request per FIFO |
| fifo_hungry | input | 8 | Hungry request per FIFO |
| ext_req | input | 4 | External peripheral request lines |
| ext_done | input | 2 | Completion pulses for external lines 0 and 1 |
| grant_idx | output | 4 | Granted channel number |
| grant_vld | output | 1 | A grant is present this cycle |
| grant_ack | output | 16 | One-hot acknowledge of the granted channel |

## Verification
Two events can land on an external pending flag in the same cycle. One is a fresh rising edge of the request. The other is its clear, which comes from the grant for lines 2 and 3 and from the done pulse for lines 0 and 1. The bench provokes the grant case by holding line 2 off with a higher-priority internal channel, then releasing that channel on the cycle the line rises again. It provokes the done case by raising line 0 and its done input together. The outcome is judged at the ports only: a surviving flag must produce further grants of that channel, and a cleared flag must leave grant_vld low.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned ARB_CH_N    = 16;
  localparam int unsigned ARB_LVL_W   = 4;
  localparam int unsigned ARB_EXT_N   = 4;
  localparam int unsigned ARB_DONE_N  = 2;

  typedef enum logic {
    ARB_PRIO = 1'b0,
    ARB_RR   = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dma_req_gather.sv
module dma_req_gather #(
  parameter int unsigned NCH   = 16,
  parameter int unsigned NEXT  = 4,
  parameter int unsigned NDONE = 2,
  parameter int unsigned IW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH/2-1:0]  fifo_wm,
  input  logic [NCH/2-1:0]  fifo_hungry,
  input  logic [NEXT-1:0]   ext_req,
  input  logic [NDONE-1:0]  ext_done,
  input  logic [NCH-1:0]    chan_en,
  input  logic              win_vld,
  input  logic [IW-1:0]     win_idx,
  output logic [NCH-1:0]    req_elig
);
  localparam int unsigned NFIFO    = NCH / 2;
  localparam int unsigned EXT_BASE = NCH - NEXT;

  logic [NEXT-1:0] ext_q, ext_q_nxt;
  logic [NEXT-1:0] pend_q, pend_nxt;
  logic [NEXT-1:0] rise, clr;
  logic [NCH-1:0]  int_req, ext_map;

  // internal request vector: even = watermark, odd = hungry
  for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
    assign int_req[2*f]   = fifo_wm[f];
    assign int_req[2*f+1] = fifo_hungry[f];
  end

  assign rise = ext_req & ~ext_q;

  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    if (k < NDONE) begin : g_done
      assign clr[k] = ext_done[k];
    end else begin : g_auto
      assign clr[k] = win_vld && (win_idx == IW'(EXT_BASE + k));
    end

    // R3 R4: flag clears unless a fresh rising edge arrives together
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && !rise[k]) |=> !pend_q[k]);
  end

  always_comb begin
    ext_q_nxt = ext_req;
    pend_nxt  = rise | (pend_q & ~clr);
    ext_map   = '0;
    for (int k = 0; k < int'(NEXT); k++) begin
      ext_map[EXT_BASE + k] = pend_q[k];
    end
    req_elig = (int_req | ext_map) & chan_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= '0;
      pend_q <= '0;
    end else begin
      ext_q  <= ext_q_nxt;
      pend_q <= pend_nxt;
    end
  end

  // R2: a rising edge always leaves the flag set
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/dma_lvl_qual.sv
module dma_lvl_qual #(
  parameter int unsigned NCH = 16,
  parameter int unsigned LW  = 4
) (
  input  logic [NCH-1:0]    req_elig,
  input  logic [NCH*LW-1:0] chan_prio,
  input  logic              rr_mode,
  output logic [NCH-1:0]    cand
);
  logic [LW-1:0] top_lvl;

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < int'(NCH); i++) begin
      if (req_elig[i] && (chan_prio[i*LW +: LW] > top_lvl)) begin
        top_lvl = chan_prio[i*LW +: LW];
      end
    end
    for (int i = 0; i < int'(NCH); i++) begin
      cand[i] = req_elig[i] && (rr_mode || (chan_prio[i*LW +: LW] == top_lvl));
    end
  end
endmodule

// File: rtl/dma_rot_pick.sv
module dma_rot_pick #(
  parameter int unsigned NCH = 16,
  parameter int unsigned IW  = 4
) (
  input  logic [NCH-1:0] cand,
  input  logic [IW-1:0]  last_idx,
  output logic           pick_vld,
  output logic [IW-1:0]  pick_idx
);
  always_comb begin
    int c;
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int k = 1; k <= int'(NCH); k++) begin
      c = (int'(last_idx) + k) % int'(NCH);
      if (!pick_vld && cand[c]) begin
        pick_vld = 1'b1;
        pick_idx = IW'(c);
      end
    end
  end
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH   = ARB_CH_N,
  parameter int unsigned LW    = ARB_LVL_W,
  parameter int unsigned NEXT  = ARB_EXT_N,
  parameter int unsigned NDONE = ARB_DONE_N,
  localparam int unsigned IW   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rr,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH*LW-1:0] chan_prio,
  input  logic [NCH/2-1:0]  fifo_wm,
  input  logic [NCH/2-1:0]  fifo_hungry,
  input  logic [NEXT-1:0]   ext_req,
  input  logic [NDONE-1:0]  ext_done,
  output logic [IW-1:0]     grant_idx,
  output logic              grant_vld,
  output logic [NCH-1:0]    grant_ack
);
  logic [1:0]     rst_sync;
  logic           rst_n_s;
  arb_mode_e      mode;
  logic [NCH-1:0] req_elig, cand;
  logic           win_vld;
  logic [IW-1:0]  win_idx;
  logic [IW-1:0]  last_q, last_nxt;
  logic [IW-1:0]  idx_nxt;
  logic           vld_nxt;
  logic [NCH-1:0] ack_nxt;
  logic [LW-1:0]  win_lvl;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  assign mode = arb_mode_e'(mode_rr);

  dma_req_gather #(.NCH(NCH), .NEXT(NEXT), .NDONE(NDONE), .IW(IW)) u_gather (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .fifo_wm    (fifo_wm),
    .fifo_hungry(fifo_hungry),
    .ext_req    (ext_req),
    .ext_done   (ext_done),
    .chan_en    (chan_en),
    .win_vld    (win_vld),
    .win_idx    (win_idx),
    .req_elig   (req_elig)
  );

  dma_lvl_qual #(.NCH(NCH), .LW(LW)) u_qual (
    .req_elig (req_elig),
    .chan_prio(chan_prio),
    .rr_mode  (mode == ARB_RR),
    .cand     (cand)
  );

  dma_rot_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .cand    (cand),
    .last_idx(last_q),
    .pick_vld(win_vld),
    .pick_idx(win_idx)
  );

  always_comb begin
    vld_nxt  = win_vld;
    idx_nxt  = win_vld ? win_idx : '0;
    last_nxt = win_vld ? win_idx : last_q;
    ack_nxt  = '0;
    if (win_vld) ack_nxt[win_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      grant_vld <= 1'b0;
      grant_idx <= '0;
      grant_ack <= '0;
      last_q    <= IW'(NCH - 1);
    end else begin
      grant_vld <= vld_nxt;
      grant_idx <= idx_nxt;
      grant_ack <= ack_nxt;
      last_q    <= last_nxt;
    end
  end

  assign win_lvl = chan_prio[win_idx*LW +: LW];

  // R5
  en_grant_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    win_vld |-> (chan_en[win_idx] && req_elig[win_idx]));

  // R7
  for (genvar g = 0; g < NCH; g++) begin : g_lvl_chk
    prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (win_vld && (mode == ARB_PRIO) && req_elig[g]) |-> (chan_prio[g*LW +: LW] <= win_lvl));
  end

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_elig == '0) |=> !grant_vld);

  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    grant_vld ? (grant_ack == (NCH'(1) << grant_idx)) : (grant_ack == '0));
endmodule

// File: tb/dma_chan_arb_tb.sv
`timescale 1ns/1ps
module dma_chan_arb_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_rr;
  logic [15:0] chan_en;
  logic [63:0] chan_prio;
  logic [7:0]  fifo_wm, fifo_hungry;
  logic [3:0]  ext_req;
  logic [1:0]  ext_done;
  logic [3:0]  grant_idx;
  logic        grant_vld;
  logic [15:0] grant_ack;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  dma_chan_arb u_dut (
    .clk(clk), .rst_n(rst_n), .mode_rr(mode_rr), .chan_en(chan_en),
    .chan_prio(chan_prio), .fifo_wm(fifo_wm), .fifo_hungry(fifo_hungry),
    .ext_req(ext_req), .ext_done(ext_done), .grant_idx(grant_idx),
    .grant_vld(grant_vld), .grant_ack(grant_ack)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ev, input int ei, input string tag);
    logic [15:0] ea;
    ea = ev ? (16'h1 << ei) : 16'h0;
    n_chk++;
    if (grant_vld !== ev || (ev && grant_idx !== 4'(ei)) || grant_ack !== ea) begin
      n_fail++;
      $display("FAIL %s: vld=%0b idx=%0d ack=%h expected vld=%0b idx=%0d ack=%h",
               tag, grant_vld, grant_idx, grant_ack, ev, ei, ea);
    end
  endtask

  task automatic set_lvl(input int ch, input int lvl);
    chan_prio[ch*4 +: 4] = 4'(lvl);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode_rr = 1'b1; chan_en = '1; chan_prio = '0;
    fifo_wm = '0; fifo_hungry = '0; ext_req = '0; ext_done = '0;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk(1'b0, 0, "R11 reset state");
  endtask

  task automatic t_map();
    do_reset();
    fifo_wm[3] = 1'b1;            tick(); chk(1'b1, 6, "R1 wm3->ch6");
    fifo_wm = '0; fifo_hungry[5] = 1'b1; tick(); chk(1'b1, 11, "R1 hungry5->ch11");
  endtask

  task automatic t_rr();
    do_reset();
    set_lvl(9, 15);
    fifo_wm[1] = 1'b1; fifo_hungry[2] = 1'b1; fifo_hungry[4] = 1'b1;
    tick(); chk(1'b1, 2, "R9 rr first");
    tick(); chk(1'b1, 5, "R9 rr second");
    tick(); chk(1'b1, 9, "R9 rr third");
    tick(); chk(1'b1, 2, "R9 rr wrap");
  endtask

  task automatic t_prio();
    do_reset();
    mode_rr = 1'b0;
    set_lvl(9, 15); set_lvl(5, 7); set_lvl(2, 3);
    fifo_wm[1] = 1'b1; fifo_hungry[2] = 1'b1; fifo_hungry[4] = 1'b1;
    tick(); chk(1'b1, 9, "R7 top level");
    tick(); chk(1'b1, 9, "R7 top level held");
    fifo_hungry[4] = 1'b0;
    tick(); chk(1'b1, 5, "R7 next level");
  endtask

  task automatic t_tie();
    do_reset();
    mode_rr = 1'b0;
    set_lvl(1, 6); set_lvl(4, 6); set_lvl(10, 6); set_lvl(3, 2);
    fifo_hungry[0] = 1'b1; fifo_wm[2] = 1'b1; fifo_wm[5] = 1'b1; fifo_hungry[1] = 1'b1;
    tick(); chk(1'b1, 1, "R8 tie a");
    tick(); chk(1'b1, 4, "R8 tie b");
    tick(); chk(1'b1, 10, "R8 tie c");
    tick(); chk(1'b1, 1, "R8 tie wrap");
  endtask

  task automatic t_disable();
    do_reset();
    fifo_wm[1] = 1'b1; fifo_hungry[2] = 1'b1; chan_en[5] = 1'b0;
    tick(); chk(1'b1, 2, "R5 rr masked");
    tick(); chk(1'b1, 2, "R5 rr masked again");
    mode_rr = 1'b0; set_lvl(5, 15);
    tick(); chk(1'b1, 2, "R5 prio masked");
    chan_en[2] = 1'b0;
    tick(); chk(1'b0, 0, "R5 all masked");
  endtask

  task automatic t_latency();
    do_reset();
    fifo_wm[7] = 1'b1;
    #1 chk(1'b0, 0, "R6 not before edge");
    tick(); chk(1'b1, 14, "R6 after edge");
    fifo_wm[7] = 1'b0;
    tick(); chk(1'b0, 0, "R6 idle");
  endtask

  task automatic t_ext_auto();
    do_reset();
    ext_req[2] = 1'b1;
    tick(); chk(1'b0, 0, "R2 flag set, no grant yet");
    tick(); chk(1'b1, 14, "R2 ext2 granted");
    tick(); chk(1'b0, 0, "R3 cleared by grant");
    // same-cycle grant and new rising edge
    mode_rr = 1'b0; set_lvl(0, 15);
    ext_req[2] = 1'b0; fifo_wm[0] = 1'b1;
    tick();
    ext_req[2] = 1'b1;
    tick(); chk(1'b1, 0, "R3 ext2 held off");
    ext_req[2] = 1'b0;
    tick();
    fifo_wm[0] = 1'b0; ext_req[2] = 1'b1;
    tick(); chk(1'b1, 14, "R3 grant with new edge");
    tick(); chk(1'b1, 14, "R3 set wins over grant");
    tick(); chk(1'b0, 0, "R3 cleared afterwards");
  endtask

  task automatic t_ext_done();
    do_reset();
    ext_req[0] = 1'b1;
    tick(); chk(1'b0, 0, "R4 flag set");
    ext_req[0] = 1'b0;
    tick(); chk(1'b1, 12, "R4 granted");
    tick(); chk(1'b1, 12, "R4 survives grant");
    ext_done[0] = 1'b1;
    tick(); chk(1'b1, 12, "R4 grant at done edge");
    ext_done[0] = 1'b0;
    tick(); chk(1'b0, 0, "R4 cleared by done");
    ext_req[0] = 1'b1; ext_done[0] = 1'b1;
    tick(); chk(1'b0, 0, "R4 set with done");
    ext_done[0] = 1'b0; ext_req[0] = 1'b0;
    tick(); chk(1'b1, 12, "R4 set wins over done");
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_map();
    t_rr();
    t_prio();
    t_tie();
    t_disable();
    t_latency();
    t_ext_auto();
    t_ext_done();
    finish_run();
  end
endmodule